// File: doc/BRIEF.md
# Multi-source reset timeout sequencer

This block produces an active-low system reset from a set of undervoltage fault flags and an active-low manual reset request. The flags come from analog comparators outside the block and are asynchronous to its clock, as is the manual request. Reset is held low for as long as any source reports a fault. Once every source is quiet, reset stays low for one selectable timeout period before it is released. A fault that returns during that period starts the count again from zero.

The manual request passes through a two-flop synchronizer and then a glitch filter, so short noise pulses cannot start a reset. A prescaler derives a one-microsecond tick from the system clock, and the timeout is counted in those ticks. A parameter selects the pad driver style: push-pull, which drives both levels, or open-drain, which only ever pulls low. The block is placed next to the supply comparators and drives the board or core reset network.

Top module: `rstseq_top`

## Requirements
- R1: Raising any bit of `uv_fault` (bit i is monitor i, 1 means undervoltage) drives `sysrst_n` low on the third rising clock edge after the change. At the second edge `sysrst_n` is still at its old level.
- R2: While `mr_n` is held low, `sysrst_n` stays low. After `mr_n` returns high, `sysrst_n` rises on edge 3 + C*P, where C = CLK_HZ/1,000,000 clock cycles per tick and P is the selected period in ticks.
- R3: When the last supply fault clears, and `mr_n` is high, `sysrst_n` rises on edge 2 + C*P counted from the clearing.
- R4: A fault seen during the timeout window restarts the count from zero. Release then happens 2 + C*P edges after that fault clears, even if it lasted only one clock cycle.
- R5: `tmo_sel` picks the period: code 1 selects PER_A (shortest), 2 selects PER_B, 3 selects PER_C, 5 selects PER_D, 6 selects PER_E and 4 selects PER_F (longest). The unused codes 0 and 7 also select PER_F. The defaults are 1650, 13200, 210000, 420000, 840000 and 1680000 ticks.
- R6: A low pulse on `mr_n` that lasts fewer than FILT_CYCLES clock cycles leaves `sysrst_n` high. A low pulse of exactly FILT_CYCLES cycles drives `sysrst_n` low on edge 3 + FILT_CYCLES after the pulse starts.
- R7: With OPEN_DRAIN = 0, `pad_out` equals `sysrst_n` and `pad_oe` is 1. With OPEN_DRAIN = 1, `pad_out` is 0 and `pad_oe` equals the inverse of `sysrst_n`.
- R8: While `rst_n` is low, `sysrst_n` is low. After `rst_n` is released with no fault present, `sysrst_n` rises on edge C*P.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Synchronous active-low reset of the block's registers |
| uv_fault | input | NUM_MON | Asynchronous undervoltage flags; 1 means fault |
| mr_n | input | 1 | Asynchronous active-low manual reset request |
| tmo_sel | input | 3 | Timeout option code (see R5) |
| sysrst_n | output | 1 | Logical system reset, active low |
| pad_out | output | 1 | Value offered to the reset pad driver |
| pad_oe | output | 1 | Output enable of the reset pad driver |

## Verification
The hardest case to reach from the ports is a fault that returns inside the timeout window for only one clock cycle. It must pass both synchronizer flops and still clear a count that has already advanced part way. The bench first lets the window run for several ticks and then drives a single-cycle pulse on one flag. It measures the release edge exactly from the end of that pulse, so a count that was not cleared gives a release that comes too early. The filter threshold is probed with pulses one cycle short of FILT_CYCLES and exactly FILT_CYCLES long, and each timeout code is measured by counting edges.

// File: rtl/rstseq_pkg.sv
// Package: shared types and helpers for the reset timeout sequencer.
// Assumes option codes are three bits wide; unused codes fall back to the
// longest period so that a bad selection never shortens a reset.
package rstseq_pkg;

    typedef logic [2:0] tmo_code_t;

    // Map an option code onto one of six periods given in ascending order.
    function automatic int unsigned pick_period(
        input tmo_code_t   code,
        input int unsigned per_a,
        input int unsigned per_b,
        input int unsigned per_c,
        input int unsigned per_d,
        input int unsigned per_e,
        input int unsigned per_f
    );
        int unsigned r;
        case (code)
            3'd1:    r = per_a;
            3'd2:    r = per_b;
            3'd3:    r = per_c;
            3'd5:    r = per_d;
            3'd6:    r = per_e;
            default: r = per_f;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
// Two-flop synchronizer for a vector of independent asynchronous bits.
// Assumes each bit is a slow level; no bus coherence between bits is implied.
module rstseq_sync #(
    parameter int unsigned      W        = 1,
    parameter logic [W-1:0]     INIT_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] stage1;

    // Shift the asynchronous input through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= INIT_VAL;
            q_sync <= INIT_VAL;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end

endmodule

// File: rtl/rstseq_glitch_filter.sv
// Glitch filter for the synchronized manual request (active low).
// The request is accepted only after FILT_CYCLES consecutive low samples;
// it is dropped on the first high sample. Assumes FILT_CYCLES >= 1.
module rstseq_glitch_filter #(
    parameter int unsigned FILT_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n_sync,
    output logic req_active
);

    localparam int unsigned FW   = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;
    localparam logic [FW-1:0] LAST = FW'(FILT_CYCLES - 1);

    logic [FW-1:0] low_cnt;

    // Count consecutive low samples and raise the request at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt    <= '0;
            req_active <= 1'b0;
        end else if (req_n_sync) begin
            low_cnt    <= '0;
            req_active <= 1'b0;
        end else if (low_cnt == LAST) begin
            req_active <= 1'b1;
        end else begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rstseq_tick_gen.sv
// Prescaler producing a one-cycle tick every microsecond of CLK_HZ.
// A synchronous clear restarts the tick phase, so the first tick always
// comes a full tick interval after the clear. Assumes CLK_HZ >= 1 MHz.
module rstseq_tick_gen #(
    parameter int unsigned CLK_HZ = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);

    localparam int unsigned CYC = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;
    localparam int unsigned PW  = (CYC > 1) ? $clog2(CYC) : 1;
    localparam logic [PW-1:0] WRAP = PW'(CYC - 1);

    logic [PW-1:0] pcnt;

    // Tick is high during the last cycle of each prescaler round.
    assign tick = (pcnt == WRAP);

    // Advance the prescaler, wrapping on tick and restarting on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pcnt <= '0;
        end else if (tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

endmodule

// File: rtl/rstseq_timer.sv
// Timeout core: holds reset while a fault is present and for the selected
// number of ticks after the last fault clears. A fault at any point
// restarts the count. Assumes every period parameter is at least 1.
module rstseq_timer
    import rstseq_pkg::*;
#(
    parameter int unsigned PER_A = 1650,
    parameter int unsigned PER_B = 13200,
    parameter int unsigned PER_C = 210000,
    parameter int unsigned PER_D = 420000,
    parameter int unsigned PER_E = 840000,
    parameter int unsigned PER_F = 1680000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fault,
    input  logic      tick,
    input  tmo_code_t code,
    output logic      hold_rst
);

    localparam int unsigned CW = $clog2(PER_F + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    // Last count value of the selected period.
    always_comb begin
        limit = CW'(pick_period(code, PER_A, PER_B, PER_C, PER_D, PER_E, PER_F) - 1);
    end

    // Hold, restart or count down the reset window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_rst <= 1'b1;
            cnt      <= '0;
        end else if (fault) begin
            hold_rst <= 1'b1;
            cnt      <= '0;
        end else if (hold_rst && tick) begin
            if (cnt >= limit) begin
                hold_rst <= 1'b0;
                cnt      <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rstseq_top.sv
// Top of the reset timeout sequencer. Synchronizes NUM_MON fault flags and
// the manual request, filters the request, and times the reset release.
// The output style is chosen at elaboration by OPEN_DRAIN.
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int unsigned NUM_MON     = 3,
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned FILT_CYCLES = 10,
    parameter int unsigned PER_A       = 1650,
    parameter int unsigned PER_B       = 13200,
    parameter int unsigned PER_C       = 210000,
    parameter int unsigned PER_D       = 420000,
    parameter int unsigned PER_E       = 840000,
    parameter int unsigned PER_F       = 1680000,
    parameter bit          OPEN_DRAIN  = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_MON-1:0] uv_fault,
    input  logic               mr_n,
    input  logic [2:0]         tmo_sel,
    output logic               sysrst_n,
    output logic               pad_out,
    output logic               pad_oe
);

    logic [NUM_MON-1:0] uv_sync;
    logic               mr_sync;
    logic               mr_flt;
    logic               fault_any;
    logic               tick;
    logic               hold_rst;

    rstseq_sync #(.W(NUM_MON), .INIT_VAL('0)) u_uv_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (uv_fault),
        .q_sync  (uv_sync)
    );

    rstseq_sync #(.W(1), .INIT_VAL(1'b1)) u_mr_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (mr_n),
        .q_sync  (mr_sync)
    );

    rstseq_glitch_filter #(.FILT_CYCLES(FILT_CYCLES)) u_mr_filt (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_n_sync (mr_sync),
        .req_active (mr_flt)
    );

    // Any synchronized supply fault or accepted manual request.
    assign fault_any = (|uv_sync) | mr_flt;

    rstseq_tick_gen #(.CLK_HZ(CLK_HZ)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fault_any),
        .tick  (tick)
    );

    rstseq_timer #(
        .PER_A (PER_A), .PER_B (PER_B), .PER_C (PER_C),
        .PER_D (PER_D), .PER_E (PER_E), .PER_F (PER_F)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .fault    (fault_any),
        .tick     (tick),
        .code     (tmo_sel),
        .hold_rst (hold_rst)
    );

    assign sysrst_n = ~hold_rst;

    // Pad driver style picked at elaboration.
    generate
        if (OPEN_DRAIN) begin : g_od
            assign pad_out = 1'b0;
            assign pad_oe  = hold_rst;
        end else begin : g_pp
            assign pad_out = ~hold_rst;
            assign pad_oe  = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/rstseq_checker.sv
// Checker bound to rstseq_top: properties over the fault summary, the tick,
// the filter and the reset outputs.
module rstseq_checker #(
    parameter bit OPEN_DRAIN = 1'b0
) (
    input logic clk,
    input logic rst_n,
    input logic fault_any,
    input logic tick,
    input logic mr_sync,
    input logic mr_flt,
    input logic sysrst_n,
    input logic pad_out,
    input logic pad_oe
);

    p_fault_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fault_any |=> !sysrst_n)
        else $error("p_fault_holds_r1");

    p_release_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sysrst_n) |-> ($past(tick) && !$past(fault_any)))
        else $error("p_release_on_tick_r3");

    p_stays_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sysrst_n && !fault_any) |=> sysrst_n)
        else $error("p_stays_released_r3");

    p_filter_needs_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mr_flt) |-> !$past(mr_sync))
        else $error("p_filter_needs_low_r6");

    generate
        if (OPEN_DRAIN) begin : g_od_chk
            p_pad_style_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (pad_out == 1'b0) && (pad_oe == !sysrst_n))
                else $error("p_pad_style_r7");
        end else begin : g_pp_chk
            p_pad_style_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (pad_out == sysrst_n) && pad_oe)
                else $error("p_pad_style_r7");
        end
    endgenerate

endmodule

bind rstseq_top rstseq_checker #(.OPEN_DRAIN(OPEN_DRAIN)) u_rstseq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault_any (fault_any),
    .tick      (tick),
    .mr_sync   (mr_sync),
    .mr_flt    (mr_flt),
    .sysrst_n  (sysrst_n),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
);

// File: tb/test_rstseq_top.sv
// Directed bench for rstseq_top: one task per scenario, each checking its
// own results against edge counts derived from the requirements.
module test_rstseq_top;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 4_000_000;
    localparam int C          = CLK_HZ / 1_000_000;
    localparam int FILT       = 3;
    localparam int PA = 5, PB = 7, PC = 9, PD = 11, PE = 13, PF = 15;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] uv_fault;
    logic       mr_n;
    logic [2:0] tmo_sel;
    logic       sysrst_n, pad_out, pad_oe;
    logic       sysrst_n_od, pad_out_od, pad_oe_od;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rstseq_top #(
        .NUM_MON(3), .CLK_HZ(CLK_HZ), .FILT_CYCLES(FILT),
        .PER_A(PA), .PER_B(PB), .PER_C(PC), .PER_D(PD), .PER_E(PE), .PER_F(PF),
        .OPEN_DRAIN(1'b0)
    ) i_rstseq_top (
        .clk(clk), .rst_n(rst_n), .uv_fault(uv_fault), .mr_n(mr_n),
        .tmo_sel(tmo_sel), .sysrst_n(sysrst_n), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    rstseq_top #(
        .NUM_MON(3), .CLK_HZ(CLK_HZ), .FILT_CYCLES(FILT),
        .PER_A(PA), .PER_B(PB), .PER_C(PC), .PER_D(PD), .PER_E(PE), .PER_F(PF),
        .OPEN_DRAIN(1'b1)
    ) i_rstseq_top_od (
        .clk(clk), .rst_n(rst_n), .uv_fault(uv_fault), .mr_n(mr_n),
        .tmo_sel(tmo_sel), .sysrst_n(sysrst_n_od), .pad_out(pad_out_od), .pad_oe(pad_oe_od)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count rising edges until sysrst_n is seen high; starts at a negedge.
    task automatic measure_rise(output int k);
        k = -1;
        for (int i = 1; i <= 2000; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (sysrst_n) begin
                k = i;
                break;
            end
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int period_of(input int code);
        case (code)
            1: return PA;
            2: return PB;
            3: return PC;
            5: return PD;
            6: return PE;
            default: return PF;
        endcase
    endfunction

    // R8 and R7: reset state, pad style, release after power-on.
    task automatic t_por();
        int k;
        rst_n = 1'b0; uv_fault = '0; mr_n = 1'b1; tmo_sel = 3'd1;
        step(4);
        check(sysrst_n == 1'b0, "R8 reset state", sysrst_n, 0);
        check(pad_out == 1'b0 && pad_oe == 1'b1, "R7 push-pull asserted", {pad_out, pad_oe}, 1);
        check(pad_out_od == 1'b0 && pad_oe_od == 1'b1, "R7 open-drain asserted", {pad_out_od, pad_oe_od}, 1);
        rst_n = 1'b1;
        measure_rise(k);
        check(k == C * PA, "R8 power-on release edge", k, C * PA);
        check(pad_out == 1'b1 && pad_oe == 1'b1, "R7 push-pull released", {pad_out, pad_oe}, 3);
        check(pad_out_od == 1'b0 && pad_oe_od == 1'b0, "R7 open-drain released", {pad_out_od, pad_oe_od}, 0);
    endtask

    // R1 and R3: each monitor asserts with exact latency and releases exactly.
    task automatic t_supply(input int mon, input int code);
        int k;
        tmo_sel = 3'(code);
        uv_fault[mon] = 1'b1;
        step(2);
        check(sysrst_n == 1'b1, "R1 not yet asserted at edge 2", sysrst_n, 1);
        step(1);
        check(sysrst_n == 1'b0, "R1 asserted at edge 3", sysrst_n, 0);
        step(5);
        uv_fault[mon] = 1'b0;
        measure_rise(k);
        check(k == 2 + C * period_of(code), "R3 release after supply fault", k, 2 + C * period_of(code));
    endtask

    // R4: a one-cycle fault inside the window restarts the count.
    task automatic t_restart();
        int k;
        tmo_sel = 3'd1;
        uv_fault[1] = 1'b1;
        step(6);
        uv_fault[1] = 1'b0;
        step(12);
        check(sysrst_n == 1'b0, "R4 still in window", sysrst_n, 0);
        uv_fault[2] = 1'b1;
        step(0);
        @(posedge clk);
        @(negedge clk);
        uv_fault[2] = 1'b0;
        measure_rise(k);
        check(k == 2 + C * PA, "R4 restart from pulse end", k, 2 + C * PA);
    endtask

    // R5: option codes including non-monotonic and unused ones.
    task automatic t_code(input int code);
        int k;
        tmo_sel = 3'(code);
        uv_fault[0] = 1'b1;
        step(5);
        uv_fault[0] = 1'b0;
        measure_rise(k);
        check(k == 2 + C * period_of(code), "R5 period for code", k, 2 + C * period_of(code));
    endtask

    // R6 and R2: filter threshold and held manual request.
    task automatic t_manual();
        int k;
        int lows;
        tmo_sel = 3'd1;
        // Pulse one cycle short of the threshold: no reset.
        mr_n = 1'b0;
        step(FILT - 1);
        mr_n = 1'b1;
        lows = 0;
        for (int i = 0; i < 12; i++) begin
            step(1);
            if (!sysrst_n) lows++;
        end
        check(lows == 0, "R6 short pulse ignored", lows, 0);
        // Pulse exactly at the threshold: reset asserts at edge 3+FILT.
        mr_n = 1'b0;
        step(FILT);
        mr_n = 1'b1;
        step(2);
        check(sysrst_n == 1'b1, "R6 not asserted before edge 3+FILT", sysrst_n, 1);
        step(1);
        check(sysrst_n == 1'b0, "R6 asserted at edge 3+FILT", sysrst_n, 0);
        measure_rise(k);
        check(k == C * PA, "R2 release after threshold pulse", k, C * PA);
        // Long hold: reset low throughout, exact release.
        mr_n = 1'b0;
        lows = 0;
        step(FILT + 3);
        for (int i = 0; i < 80; i++) begin
            step(1);
            if (!sysrst_n) lows++;
        end
        check(lows == 80, "R2 held while manual low", lows, 80);
        mr_n = 1'b1;
        measure_rise(k);
        check(k == 3 + C * PA, "R2 release after manual high", k, 3 + C * PA);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_por();
        t_supply(0, 1);
        t_supply(1, 2);
        t_supply(2, 3);
        t_restart();
        t_code(4);
        t_code(5);
        t_code(6);
        t_code(0);
        t_code(7);
        t_manual();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule